// File: doc/BRIEF.md
# Memory Controller Performance Counter Bank

This block holds a small set of performance counters for a DRAM controller. Counter 0 counts clock cycles and nothing else. Each of the other counters counts one event that software chooses from a vector of single-cycle event strobes. Software programs the counters through a flat 32-bit register window. Each counter has a control word and a read-only count word.

The cycle counter gates the whole bank. When it is disabled, or after it has wrapped, no counter in the bank moves. A wrap of the cycle counter also raises the single interrupt line. The interrupt stays high until software clears the cycle counter. Software can load a bias into a byte of a counter when it clears that counter, so a sampling period can be made shorter.

A three-state gate machine holds the bank condition:

- `ST_HALT`: the cycle counter is disabled.
- `ST_COUNT`: counting is allowed.
- `ST_FROZEN`: the cycle counter has wrapped.

It moves between these states as follows:

- HALT to COUNT when the cycle counter is enabled.
- COUNT to HALT when the cycle counter is disabled.
- COUNT to FROZEN on a wrap of the cycle counter.
- FROZEN to COUNT or HALT on a clear action of the cycle counter. The target state follows the enable bit written with that clear.

A clear action on counter 0 always takes priority over a wrap in the same cycle.

Top module: `mcperf_bank`

## Requirements
- R1: After reset, every control and count word reads 0, `irq` is low and the gate machine is in HALT.
- R2: Word address 4n holds the control word of counter n, and word address 0x20+4n holds its count, zero-extended. The control word has the following fields:
  - bit 0: overflow flag
  - bit 1: clear
  - bit 2: enable
  - bits [23:16]: preload byte
  - bits [31:24]: event code

  Every other address reads 0.
- R3: Counter 0 adds one on each clock edge at which the machine is in COUNT. Its event code is stored but has no effect on counting.
- R4: An event counter adds one on each edge at which all of these hold: the machine is in COUNT, its enable bit is 1, and its selected strobe is high. The event codes map as follows:
  - 0x00: always high
  - 0x04: `event_i[0]`
  - 0x05: `event_i[1]`
  - 0x20: `event_i[2]`
  - 0x21: `event_i[3]`
  - 0x41: `event_i[4]`
  - 0x42: `event_i[5]`

  Any other code never counts.
- R5: Writing a control word of an event counter with the clear bit at 0 performs a clear action. The clear bit then reads back as 1. A write with the clear bit at 1 leaves the count alone.
- R6: For counter 0, a clear action happens only on a write that sets the clear bit while the stored clear bit is 0. A write of 1 over a stored 1 does not clear.
- R7: A clear action loads the count with the written preload byte at bits [PRE_LSB+7:PRE_LSB] (0 when PRELOAD_EN is 0) and resets the overflow flag.
- R8: When counter 0 wraps, its count becomes 0 and its overflow flag is set. The machine enters FROZEN, and no counter changes until the next clear action on counter 0.
- R9: `irq` equals the overflow flag of counter 0. It stays high until a clear action on counter 0.
- R10: While counter 0 is disabled (HALT), no counter changes. Enabling counter 0 again without a clear resumes all counters from their held values.
- R11: An event counter that wraps sets its own overflow flag but never raises `irq`. With STOP_ON_OVF=1 it then holds at all-ones until cleared. With STOP_ON_OVF=0 it wraps through 0 and keeps counting.
- R12: The overflow bit of a control word is read-only, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe for one cycle |
| addr | input | ADDR_W | Byte address of the register, word aligned |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| event_i | input | 6 | Event strobes from the controller |
| irq | output | 1 | Cycle counter overflow interrupt |

## Verification
The bound checker watches the following on every cycle:
- Counters stay still in HALT and FROZEN.
- An event counter only ever holds or steps by one.
- `irq` only rises out of COUNT and is sticky without a write.
- A stopped event counter holds after overflow.

The following can only be shown by the bench's scenarios, against counts it tallies itself:
- The exact totals, under random strobes.
- The two clear protocols.
- The preload position.
- The wrap point of the cycle counter.
- Wrap against saturate in the two overflow modes.

// File: rtl/mcperf_pkg.sv
package mcperf_pkg;

    localparam int EVT_W = 6;

    typedef enum logic [1:0] {
        ST_HALT   = 2'd0,
        ST_COUNT  = 2'd1,
        ST_FROZEN = 2'd2
    } gate_st_e;

    typedef struct packed {
        logic [7:0] sel;
        logic [7:0] pre;
        logic       en;
        logic       clr;
    } ctl_wr_t;

    // Event code to strobe; unimplemented codes never count.
    function automatic logic evt_pick(input logic [7:0] code,
                                      input logic [EVT_W-1:0] strb);
        logic hit;
        case (code)
            8'h00:   hit = 1'b1;
            8'h04:   hit = strb[0];
            8'h05:   hit = strb[1];
            8'h20:   hit = strb[2];
            8'h21:   hit = strb[3];
            8'h41:   hit = strb[4];
            8'h42:   hit = strb[5];
            default: hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/mcperf_gate_fsm.sv
module mcperf_gate_fsm
    import mcperf_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     en0_nxt_i,
    input  logic     clr0_act_i,
    input  logic     wrap0_i,
    output gate_st_e state_o,
    output logic     run_o
);

    gate_st_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_HALT;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_HALT:   st_d = en0_nxt_i ? ST_COUNT : ST_HALT;
            ST_COUNT: begin
                if (clr0_act_i)   st_d = en0_nxt_i ? ST_COUNT : ST_HALT;
                else if (wrap0_i) st_d = ST_FROZEN;
                else              st_d = en0_nxt_i ? ST_COUNT : ST_HALT;
            end
            ST_FROZEN: begin
                if (clr0_act_i)   st_d = en0_nxt_i ? ST_COUNT : ST_HALT;
            end
            default:   st_d = ST_HALT;
        endcase
    end

    always_comb begin
        state_o = st_q;
        run_o   = (st_q == ST_COUNT);
    end

endmodule

// File: rtl/mcperf_ctr.sv
module mcperf_ctr
    import mcperf_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int PRE_LSB     = 16,
    parameter bit PRELOAD_EN  = 1'b1,
    parameter bit IS_CYCLE    = 1'b0,
    parameter bit STOP_ON_OVF = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  ctl_wr_t          wfld_i,
    input  logic             run_i,
    input  logic             hit_i,
    output logic [31:0]      ctl_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ovf_o,
    output logic             en_nxt_o,
    output logic             clr_act_o,
    output logic             wrap_o
);

    localparam bit HOLD_AT_MAX = STOP_ON_OVF && !IS_CYCLE;

    logic             en_q, clr_q, ovf_q;
    logic [7:0]       sel_q, pre_q;
    logic [CNT_W-1:0] cnt_q, pre_val;
    logic             inc, at_max, clr_act;

    always_comb begin
        pre_val = '0;
        if (PRELOAD_EN) pre_val[PRE_LSB +: 8] = wfld_i.pre;
    end

    generate
        if (IS_CYCLE) begin : g_cyc_clr
            assign clr_act = wr_i && wfld_i.clr && !clr_q;
        end else begin : g_evt_clr
            assign clr_act = wr_i && !wfld_i.clr;
        end
    endgenerate

    assign at_max = &cnt_q;
    assign inc    = run_i && en_q && hit_i && !(HOLD_AT_MAX && ovf_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            clr_q <= 1'b0;
            ovf_q <= 1'b0;
            sel_q <= '0;
            pre_q <= '0;
            cnt_q <= '0;
        end else begin
            if (wr_i) begin
                en_q  <= wfld_i.en;
                clr_q <= IS_CYCLE ? wfld_i.clr : 1'b1;
                sel_q <= wfld_i.sel;
                pre_q <= wfld_i.pre;
            end
            if (clr_act) begin
                cnt_q <= pre_val;
                ovf_q <= 1'b0;
            end else if (inc) begin
                if (at_max) ovf_q <= 1'b1;
                if (!(at_max && HOLD_AT_MAX)) cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign ctl_o     = {sel_q, pre_q, 13'b0, en_q, clr_q, ovf_q};
    assign cnt_o     = cnt_q;
    assign ovf_o     = ovf_q;
    assign en_nxt_o  = wr_i ? wfld_i.en : en_q;
    assign clr_act_o = clr_act;
    assign wrap_o    = inc && at_max;

endmodule

// File: rtl/mcperf_decode.sv
module mcperf_decode #(
    parameter int NUM_CTR = 4,
    parameter int ADDR_W  = 8,
    parameter int CNT_W   = 32
) (
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [NUM_CTR-1:0][31:0]      ctl_i,
    input  logic [NUM_CTR-1:0][CNT_W-1:0] cnt_i,
    output logic [NUM_CTR-1:0]            wr_ctl_o,
    output logic [31:0]                   rdata
);

    localparam int CNT_BASE = 'h20;

    always_comb begin
        rdata    = '0;
        wr_ctl_o = '0;
        for (int n = 0; n < NUM_CTR; n++) begin
            if (addr == ADDR_W'(4 * n)) begin
                rdata       = ctl_i[n];
                wr_ctl_o[n] = wr_en;
            end
            if (addr == ADDR_W'(CNT_BASE + 4 * n)) begin
                rdata[CNT_W-1:0] = cnt_i[n];
            end
        end
    end

endmodule

// File: rtl/mcperf_bank.sv
module mcperf_bank
    import mcperf_pkg::*;
#(
    parameter int NUM_CTR     = 4,
    parameter int ADDR_W      = 8,
    parameter int CNT_W       = 32,
    parameter int PRE_LSB     = 16,
    parameter bit PRELOAD_EN  = 1'b1,
    parameter bit STOP_ON_OVF = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic [EVT_W-1:0]  event_i,
    output logic              irq
);

    ctl_wr_t                       wfld;
    logic [NUM_CTR-1:0]            wr_ctl, hit_all, ovf_all;
    logic [NUM_CTR-1:0]            en_nxt_all, clr_act_all, wrap_all;
    logic [NUM_CTR-1:0][31:0]      ctl_all;
    logic [NUM_CTR-1:0][CNT_W-1:0] cnt_all;
    gate_st_e                      gate_st;
    logic                          run;

    assign wfld = '{sel: wdata[31:24], pre: wdata[23:16], en: wdata[2], clr: wdata[1]};

    logic unused_side;
    assign unused_side = ^{wdata[15:3], wdata[0], en_nxt_all[NUM_CTR-1:1],
                           clr_act_all[NUM_CTR-1:1], wrap_all[NUM_CTR-1:1]};

    mcperf_decode #(.NUM_CTR(NUM_CTR), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_decode (
        .wr_en    (wr_en),
        .addr     (addr),
        .ctl_i    (ctl_all),
        .cnt_i    (cnt_all),
        .wr_ctl_o (wr_ctl),
        .rdata    (rdata)
    );

    mcperf_gate_fsm u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .en0_nxt_i  (en_nxt_all[0]),
        .clr0_act_i (clr_act_all[0]),
        .wrap0_i    (wrap_all[0]),
        .state_o    (gate_st),
        .run_o      (run)
    );

    generate
        for (genvar n = 0; n < NUM_CTR; n++) begin : g_ctr
            if (n == 0) begin : g_hit_cyc
                assign hit_all[n] = 1'b1;
            end else begin : g_hit_evt
                assign hit_all[n] = evt_pick(ctl_all[n][31:24], event_i);
            end
            mcperf_ctr #(
                .CNT_W       (CNT_W),
                .PRE_LSB     (PRE_LSB),
                .PRELOAD_EN  (PRELOAD_EN),
                .IS_CYCLE    (n == 0),
                .STOP_ON_OVF (STOP_ON_OVF)
            ) u_ctr (
                .clk       (clk),
                .rst_n     (rst_n),
                .wr_i      (wr_ctl[n]),
                .wfld_i    (wfld),
                .run_i     (run),
                .hit_i     (hit_all[n]),
                .ctl_o     (ctl_all[n]),
                .cnt_o     (cnt_all[n]),
                .ovf_o     (ovf_all[n]),
                .en_nxt_o  (en_nxt_all[n]),
                .clr_act_o (clr_act_all[n]),
                .wrap_o    (wrap_all[n])
            );
        end
    endgenerate

    assign irq = ovf_all[0];

endmodule

// File: rtl/mcperf_bank_chk.sv
module mcperf_bank_chk
    import mcperf_pkg::*;
#(
    parameter int NUM_CTR     = 4,
    parameter int CNT_W       = 32,
    parameter bit STOP_ON_OVF = 1'b1
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          wr_en,
    input logic                          irq,
    input gate_st_e                      state,
    input logic [NUM_CTR-1:0][CNT_W-1:0] cnt,
    input logic [NUM_CTR-1:0]            ovf
);

    AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FROZEN && !wr_en) |=> $stable(cnt)); // R8

    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT && !wr_en) |=> $stable(cnt)); // R10

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !wr_en) |=> irq); // R9

    AST_IRQ_FROM_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(state == ST_COUNT)); // R8

    generate
        for (genvar i = 1; i < NUM_CTR; i++) begin : g_evt
            AST_EVT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
                (!wr_en && !ovf[i]) |=> (cnt[i] == $past(cnt[i]) ||
                    cnt[i] == CNT_W'($past(cnt[i]) + 1'b1))); // R4
            if (STOP_ON_OVF) begin : g_sat
                AST_EVT_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                    (ovf[i] && !wr_en) |=> $stable(cnt[i])); // R11
            end
        end
    endgenerate

endmodule

bind mcperf_bank mcperf_bank_chk #(
    .NUM_CTR(NUM_CTR), .CNT_W(CNT_W), .STOP_ON_OVF(STOP_ON_OVF)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .irq(irq),
    .state(gate_st), .cnt(cnt_all), .ovf(ovf_all)
);

// File: tb/mcperf_bank_bench.sv
module mcperf_bank_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [5:0]  event_i = '0;
    logic [31:0] rdata, rdata_l;
    logic        irq, irq_l;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    mcperf_bank #(.CNT_W(16), .PRE_LSB(8), .STOP_ON_OVF(1'b1)) u_mcperf_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .event_i(event_i), .irq(irq)
    );

    mcperf_bank #(.CNT_W(16), .PRE_LSB(8), .STOP_ON_OVF(1'b0)) u_mcperf_bank_legacy (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata_l), .event_i(event_i), .irq(irq_l)
    );

    function automatic logic exp_hit(input logic [7:0] code, input logic [5:0] ev);
        if (code == 8'h00) return 1'b1;
        if (code == 8'h04) return ev[0];
        if (code == 8'h05) return ev[1];
        if (code == 8'h20) return ev[2];
        if (code == 8'h21) return ev[3];
        if (code == 8'h41) return ev[4];
        if (code == 8'h42) return ev[5];
        return 1'b0;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One clock edge with the given inputs; inputs released just after it.
    task automatic cyc(input logic w, input logic [7:0] a, input logic [31:0] d,
                       input logic [5:0] ev);
        @(negedge clk);
        wr_en = w; addr = a; wdata = d; event_i = ev;
        @(posedge clk);
        #1;
        wr_en = 1'b0; event_i = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v, output logic [31:0] vl);
        addr = a;
        #1;
        v = rdata;
        vl = rdata_l;
    endtask

    initial begin
        logic [31:0] v, vl, c1, c2, c3, c0;
        int t1, t2, t3;
        void'($urandom(32'd4242));
        #35 rst_n = 1'b1;
        #1;
        // R1 reset state
        for (int a = 0; a < 16; a++) begin
            rd(8'(4 * a), v, vl);
            chk("R1 reset word", v, 32'h0);
        end
        chk("R1 irq low", {31'b0, irq}, 32'h0);

        // Event counter setup; bank in HALT, strobes high
        cyc(1, 8'h04, 32'h0, '1);
        rd(8'h04, v, vl);
        chk("R5 clear bit reads 1", v, 32'h0000_0002);
        cyc(1, 8'h04, 32'h0400_0006, '1);
        cyc(1, 8'h08, 32'h0, '1);
        cyc(1, 8'h08, 32'h2100_0006, '1);
        cyc(1, 8'h0C, 32'h0, '1);
        cyc(1, 8'h0C, 32'h4200_0006, '1);
        rd(8'h24, v, vl);
        chk("R10 halted counter 1", v, 32'h0);
        rd(8'h2C, v, vl);
        chk("R10 halted counter 3", v, 32'h0);
        rd(8'h04, v, vl);
        chk("R2 control layout", v, 32'h0400_0006);

        // Cycle counter with a stray event code (R3), random strobes (R4)
        cyc(1, 8'h00, 32'h0, '0);
        cyc(1, 8'h00, 32'h0400_0006, '0);
        rd(8'h00, v, vl);
        chk("R2 control 0 readback", v, 32'h0400_0006);
        t1 = 0; t2 = 0; t3 = 0;
        for (int k = 0; k < 200; k++) begin
            logic [5:0] ev;
            ev = 6'($urandom);
            t1 += int'(exp_hit(8'h04, ev));
            t2 += int'(exp_hit(8'h21, ev));
            t3 += int'(exp_hit(8'h42, ev));
            cyc(0, 8'h00, 32'h0, ev);
        end
        cyc(1, 8'h00, 32'h0400_0002, '0);
        rd(8'h20, v, vl);
        chk("R3 cycle total", v, 32'd201);
        rd(8'h24, c1, vl);
        chk("R4 code 0x04 tally", c1, 32'(t1));
        rd(8'h28, c2, vl);
        chk("R4 code 0x21 tally", c2, 32'(t2));
        rd(8'h2C, c3, vl);
        chk("R4 code 0x42 tally", c3, 32'(t3));

        // R10 hold and resume; counter 3 gets an unimplemented code
        cyc(1, 8'h0C, 32'h0700_0006, '0);
        for (int k = 0; k < 20; k++) cyc(0, 8'h00, 32'h0, '1);
        rd(8'h24, v, vl);
        chk("R10 hold while halted", v, c1);
        cyc(1, 8'h00, 32'h0000_0004, '0);
        for (int k = 0; k < 10; k++) cyc(0, 8'h00, 32'h0, '1);
        cyc(1, 8'h00, 32'h0, '0);
        rd(8'h20, v, vl);
        chk("R10 cycle resumes", v, 32'd212);
        rd(8'h24, v, vl);
        chk("R10 event resumes", v, c1 + 32'd10);
        rd(8'h28, v, vl);
        chk("R10 event resumes 2", v, c2 + 32'd10);
        rd(8'h2C, v, vl);
        chk("R4 unimplemented code", v, c3);

        // R12 overflow bit read-only
        cyc(1, 8'h04, 32'h0400_0007, '0);
        rd(8'h04, v, vl);
        chk("R12 overflow write ignored", v, 32'h0400_0006);
        rd(8'h10, v, vl);
        chk("R2 unmapped read", v, 32'h0);

        // R6 cycle counter clear protocol
        cyc(1, 8'h00, 32'h6, '0);
        rd(8'h20, v, vl);
        chk("R6 clear on 0 to 1", v, 32'h0);
        for (int k = 0; k < 5; k++) cyc(0, 8'h00, 32'h0, '0);
        cyc(1, 8'h00, 32'h2, '0);
        rd(8'h20, v, vl);
        chk("R6 no clear on 1 over 1", v, 32'd6);
        cyc(1, 8'h00, 32'h0, '0);
        cyc(1, 8'h00, 32'h2, '0);
        rd(8'h20, v, vl);
        chk("R6 clear after 0 then 1", v, 32'h0);

        // R5 event clear by writing 0
        cyc(1, 8'h04, 32'h0400_0004, '0);
        rd(8'h24, v, vl);
        chk("R5 count reset", v, 32'h0);
        rd(8'h04, v, vl);
        chk("R5 clear bit set after", v, 32'h0400_0006);

        // R7 preload, R8 wrap freeze
        cyc(1, 8'h00, 32'h0, '0);
        cyc(1, 8'h00, 32'h00FF_0006, '0);
        rd(8'h20, v, vl);
        chk("R7 preload position", v, 32'h0000_FF00);
        for (int k = 0; k < 300; k++) cyc(0, 8'h00, 32'h0, 6'b000001);
        rd(8'h20, v, vl);
        chk("R8 cycle wraps to 0", v, 32'h0);
        rd(8'h00, v, vl);
        chk("R8 overflow flag", v, 32'h00FF_0007);
        rd(8'h24, v, vl);
        chk("R8 event frozen", v, 32'd256);
        chk("R8 irq raised", {31'b0, irq}, 32'h1);

        // R9 sticky interrupt
        for (int k = 0; k < 10; k++) cyc(0, 8'h00, 32'h0, '1);
        chk("R9 irq held", {31'b0, irq}, 32'h1);
        cyc(1, 8'h00, 32'h00FF_0006, '0);
        chk("R9 no clear keeps irq", {31'b0, irq}, 32'h1);
        cyc(1, 8'h00, 32'h0, '0);
        chk("R9 zero write keeps irq", {31'b0, irq}, 32'h1);
        cyc(1, 8'h00, 32'h2, '0);
        chk("R9 irq cleared", {31'b0, irq}, 32'h0);
        rd(8'h20, c0, vl);
        chk("R9 cycle count cleared", c0, 32'h0);

        // R11 event overflow, saturate vs wrap
        cyc(1, 8'h08, 32'h00FF_0000, '0);
        rd(8'h08, v, vl);
        chk("R7 event preload control", v, 32'h00FF_0002);
        rd(8'h28, v, vl);
        chk("R7 event preload count", v, 32'h0000_FF00);
        cyc(1, 8'h08, 32'h00FF_0006, '0);
        cyc(1, 8'h00, 32'h6, '0);
        for (int k = 0; k < 300; k++) cyc(0, 8'h00, 32'h0, '0);
        cyc(1, 8'h00, 32'h2, '0);
        rd(8'h28, v, vl);
        chk("R11 stop mode holds", v, 32'h0000_FFFF);
        chk("R11 legacy wraps on", vl, 32'h0000_002D);
        rd(8'h08, v, vl);
        chk("R11 stop flag", v, 32'h00FF_0007);
        chk("R11 legacy flag", vl, 32'h00FF_0007);
        chk("R11 no irq", {30'b0, irq, irq_l}, 32'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule